// File: doc/BRIEF.md
# Four-Lane Unsigned Integer to Single-Precision Converter

This block takes a 128-bit word that holds four unsigned 32-bit integers and returns four IEEE-754 single-precision values in the same lane positions. Each lane is converted on its own and rounded once, to the nearest representable value, with ties going to the even mantissa. Nothing else is supported: no signed input, no scale factor, no other rounding mode and no exception flags.

A lane whose bit 31 is clear is normalised with a leading-zero count, and its dropped bits are reduced to a guard bit and a sticky bit. A lane whose bit 31 is set always loses exactly its eight lowest bits. It rounds by adding 0x7F plus input bit 8 and keeping the upper bits of the sum. This way every value at or above 2^31 is rounded once. Converting the low 31 bits as a signed number and then adding 2^31 would round twice, and the second rounding can push the result one unit too high.

Results are registered. A word presented with `valid_i` high appears on `data_o` one clock later, together with `valid_o`.

Top module: `vec_u2f_cvt`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first accepted word, `valid_o` is 0 and `data_o` is all zero.
- R2: `valid_o` equals `valid_i` from the previous rising edge. `data_o` loads only on an edge where `valid_i` is high and otherwise holds its value, whatever `data_i` does.
- R3: Lane k uses input bits [32k+31:32k] and drives output bits [32k+31:32k]. The result of one lane does not depend on the other lanes.
- R4: An input lane of 0 gives +0.0, encoded as 0x00000000.
- R5: Any input below 2^24 converts exactly: exponent field 127+p, where p is the position of the leading one, and the mantissa field holds the bits below the leading one, shifted left to fill 23 bits.
- R6: For inputs from 2^24 to 2^31-1, the result is rounded to nearest with ties to even. If rounding carries out of the mantissa, the exponent rises by one and the mantissa field becomes 0. Example: 0x01FFFFFF gives 0x4C000000.
- R7: For inputs with bit 31 set, the output has exponent field 158. Its mantissa is bits [30:8] of input + 0x7F + input bit 8, provided that sum does not carry out of bit 31.
- R8: When that sum carries out of bit 31, the lane result is 0x4F800000 (2^32). Examples: 0xFFFFFFFF and 0xFFFFFF80 give 0x4F800000, while 0xFFFFFF7F gives 0x4F7FFFFF.
- R9: Large inputs are rounded once. 0xC0000141 gives 0x4F400001, 0xFFFDFF7E gives 0x4F7FFDFF and 0xFFFCFF7D gives 0x4F7FFCFF.
- R10: Bit 31 of every output lane (the sign) is 0 whenever `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is valid and is captured at this edge |
| data_i | input | 128 | Four unsigned 32-bit integers, lane 0 in bits [31:0] |
| valid_o | output | 1 | `data_o` holds a fresh result |
| data_o | output | 128 | Four single-precision results, lane 0 in bits [31:0] |

## Verification
The checker assumes `valid_i` is never unknown and that `data_i` holds known bits whenever `valid_i` is high. The lane-level properties on zero inputs and on the bit-31 exponent compare the previous cycle's input with the present output, so they only make sense if inputs change just between edges. The stimulus drives `data_i` and `valid_i` only on falling edges, holds reset low before the first transfer, and scrambles `data_i` only while `valid_i` is low, so the hold property is exercised without breaking those assumptions.

// File: rtl/vec_u2f_pkg.sv
package vec_u2f_pkg;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned MANT_W = 23;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned BIAS   = 127;
  localparam int unsigned LZ_W   = $clog2(LANE_W);
  localparam int unsigned DROP_W = LANE_W - 1 - MANT_W;
endpackage

// File: rtl/u2f_lzc.sv
module u2f_lzc #(
  parameter int unsigned W   = 32,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  in_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  always_comb begin
    cnt_o  = '0;
    zero_o = 1'b1;
    for (int i = 0; i < int'(W); i++) begin
      if (in_i[i]) begin
        cnt_o  = CW'(int'(W) - 1 - i);
        zero_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/u2f_lane.sv
module u2f_lane
  import vec_u2f_pkg::*;
(
  input  logic [LANE_W-1:0] val_i,
  output logic [LANE_W-1:0] flt_o
);
  localparam int unsigned SW = LANE_W + 1;
  localparam logic [SW-1:0]    RND_C  = SW'((1 << (DROP_W - 1)) - 1);
  localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(BIAS + LANE_W - 1);
  localparam logic [EXP_W-1:0] EXP_OVF = EXP_W'(BIAS + LANE_W);

  // lower path: normalise, guard/sticky, single rounding
  logic [LZ_W-1:0]   lz;
  logic              is_zero;
  logic [LANE_W-1:0] norm;
  logic [MANT_W-1:0] m_lo;
  logic              guard, sticky, rnd_up;
  logic [MANT_W:0]   m_rnd;
  logic [EXP_W-1:0]  e_lo;
  logic [LANE_W-1:0] res_lo;

  u2f_lzc #(.W(LANE_W)) u_lzc (
    .in_i   (val_i),
    .cnt_o  (lz),
    .zero_o (is_zero)
  );

  always_comb begin
    norm   = val_i << lz;
    m_lo   = norm[LANE_W-2 -: MANT_W];
    guard  = norm[DROP_W-1];
    sticky = |norm[DROP_W-2:0];
    rnd_up = guard & (sticky | m_lo[0]);
    m_rnd  = {1'b0, m_lo} + {{MANT_W{1'b0}}, rnd_up};
    e_lo   = EXP_TOP - EXP_W'(lz) + {{(EXP_W-1){1'b0}}, m_rnd[MANT_W]};
    res_lo = is_zero ? '0 : {1'b0, e_lo, m_rnd[MANT_W-1:0]};
  end

  // upper path: fixed drop of DROP_W bits, round by add
  logic [SW-1:0]     h_sum;
  logic [LANE_W-1:0] res_hi;

  always_comb begin
    h_sum  = {1'b0, val_i} + RND_C + {{LANE_W{1'b0}}, val_i[DROP_W]};
    res_hi = h_sum[LANE_W] ? {1'b0, EXP_OVF, {MANT_W{1'b0}}}
                           : {1'b0, EXP_TOP, h_sum[LANE_W-2 -: MANT_W]};
  end

  assign flt_o = val_i[LANE_W-1] ? res_hi : res_lo;
endmodule

// File: rtl/vec_u2f_cvt.sv
module vec_u2f_cvt
  import vec_u2f_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] cvt;

  for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
    u2f_lane u_lane (
      .val_i (data_i[k*LANE_W +: LANE_W]),
      .flt_o (cvt[k*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= cvt;
    end
  end
endmodule

// File: rtl/vec_u2f_cvt_chk.sv
module vec_u2f_cvt_chk
  import vec_u2f_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned DW   = LANES * LANE_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [DW-1:0] data_i,
  input logic          valid_o,
  input logic [DW-1:0] data_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_valid_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == $past(valid_i));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(valid_i)) |-> $stable(data_o));

  for (genvar k = 0; k < int'(LANES); k++) begin : g_chk
    localparam int unsigned B = k * LANE_W;

    assert_sign_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> !data_o[B+LANE_W-1]);

    assert_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && $past(valid_i) && $past(data_i[B +: LANE_W]) == '0)
        |-> data_o[B +: LANE_W] == '0);

    assert_hi_exp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && $past(valid_i) && $past(data_i[B+LANE_W-1]))
        |-> (data_o[B+MANT_W +: EXP_W] == EXP_W'(BIAS + LANE_W - 1)) ||
            (data_o[B +: LANE_W] == {1'b0, EXP_W'(BIAS + LANE_W), {MANT_W{1'b0}}}));
  end
endmodule

bind vec_u2f_cvt vec_u2f_cvt_chk #(.LANES(LANES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .data_i  (data_i),
  .valid_o (valid_o),
  .data_o  (data_o)
);

// File: tb/sim_vec_u2f_cvt.sv
module sim_vec_u2f_cvt;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] data_i = '0;
  logic         valid_o;
  logic [127:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] last_q [LANES];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vec_u2f_cvt #(.LANES(LANES)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .data_i(data_i), .valid_o(valid_o), .data_o(data_o)
  );

  function automatic logic [31:0] ref_u2f(input logic [31:0] x);
    longint q, rem, half;
    int p, d, e;
    if (x == 0) return 32'h0;
    p = 0;
    for (int i = 0; i < 32; i++) if (x[i]) p = i;
    e = 127 + p;
    if (p <= 23) begin
      q = longint'(x) << (23 - p);
    end else begin
      d = p - 23;
      q = longint'(x) >> d;
      rem = longint'(x) & ((64'd1 << d) - 1);
      half = 64'd1 << (d - 1);
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q == (64'd1 << 24)) begin q = q >> 1; e = e + 1; end
    end
    return {1'b0, 8'(e), q[22:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // drives on falling edge, result sampled one cycle later on falling edge
  task automatic run_vec(input string req, input logic [31:0] a, b, c, d);
    logic [31:0] v [LANES];
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    @(negedge clk_i);
    data_i = {d, c, b, a};
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(req, "valid_o", {31'b0, valid_o}, 32'h1);
    for (int k = 0; k < LANES; k++) begin
      last_q[k] = data_o[k*32 +: 32];
      chk(req, $sformatf("lane%0d in=%08h", k, v[k]), last_q[k], ref_u2f(v[k]));
    end
  endtask

  task automatic t_reset;
    chk("R1", "valid_o in reset", {31'b0, valid_o}, 32'h0);
    chk("R1", "data_o in reset", data_o[31:0] | data_o[63:32] | data_o[95:64] | data_o[127:96], 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    chk("R1", "valid_o after reset", {31'b0, valid_o}, 32'h0);
    chk("R1", "data_o after reset", data_o[31:0] | data_o[127:96], 32'h0);
  endtask

  task automatic t_listed;
    run_vec("R9", 32'hC0000141, 32'hFFFDFF7E, 32'hFFFCFF7D, 32'hFFFFFFFF);
    chk("R9", "0xC0000141", last_q[0], 32'h4F400001);
    chk("R9", "0xFFFDFF7E", last_q[1], 32'h4F7FFDFF);
    chk("R9", "0xFFFCFF7D", last_q[2], 32'h4F7FFCFF);
    chk("R8", "0xFFFFFFFF", last_q[3], 32'h4F800000);
  endtask

  task automatic t_small;
    run_vec("R4", 32'h0, 32'h1, 32'h0, 32'h2);
    chk("R4", "zero lane", last_q[0], 32'h0);
    chk("R5", "one", last_q[1], 32'h3F800000);
    run_vec("R5", 32'h00FFFFFF, 32'h00800000, 32'h00ABCDEF, 32'h00000007);
    chk("R5", "2^24-1", last_q[0], 32'h4B7FFFFF);
  endtask

  task automatic t_bounds;
    run_vec("R6", 32'h01000000, 32'h01000001, 32'h01000003, 32'h01FFFFFF);
    chk("R6", "2^24+1 tie even", last_q[1], 32'h4B800000);
    chk("R6", "2^24+3 tie up", last_q[2], 32'h4B800002);
    chk("R6", "carry bumps exp", last_q[3], 32'h4C000000);
    run_vec("R7", 32'h7FFFFFFF, 32'h80000000, 32'h80000001, 32'h80000180);
    chk("R6", "2^31-1", last_q[0], 32'h4F000000);
    chk("R7", "2^31", last_q[1], 32'h4F000000);
    chk("R7", "tie odd up", last_q[3], 32'h4F000002);
    run_vec("R8", 32'hFFFFFF80, 32'hFFFFFF7F, 32'hFFFFFE80, 32'h80000080);
    chk("R8", "0xFFFFFF80 overflow", last_q[0], 32'h4F800000);
    chk("R8", "0xFFFFFF7F no overflow", last_q[1], 32'h4F7FFFFF);
    chk("R7", "tie even down", last_q[3], 32'h4F000000);
  endtask

  task automatic t_random;
    for (int n = 0; n < 300; n++)
      run_vec("R3", $urandom(), $urandom() | 32'h80000000, $urandom() >> ($urandom() % 32), $urandom() & 32'h7FFFFFFF);
  endtask

  task automatic t_hold;
    logic [127:0] held;
    run_vec("R2", 32'h12345678, 32'h9ABCDEF0, 32'h00000010, 32'hFFFF0000);
    held = data_o;
    @(negedge clk_i); data_i = {4{32'hDEADBEEF}};
    @(negedge clk_i); data_i = '0;
    @(negedge clk_i);
    chk("R2", "valid_o idle", {31'b0, valid_o}, 32'h0);
    for (int k = 0; k < LANES; k++)
      chk("R2", $sformatf("hold lane%0d", k), data_o[k*32 +: 32], held[k*32 +: 32]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    t_listed();
    t_small();
    t_bounds();
    t_hold();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule